// File: doc/BRIEF.md
# Shared Arbitration-Lost / Receive-Overrun Status Flag

This block sits beside the shifter of a two-wire serial port and maintains a single status bit whose meaning follows the selected bus format. With the I2C format selected and the port acting as master, the bit records that another master has won the bus. It is raised either when the level on the SDA pin disagrees with the level this port drives at a rising SCL edge during a transmit, or when a start condition is seen while this port holds SDA high. With the clocked synchronous format selected, the same bit records a receive overrun: a frame's last bit arrived while the previous byte still sat unread.

Software clears the bit with a two-step handshake. It must first read the bit as 1, then write 0 to it. A new event that arrives between those two steps cancels the pending clear, so that event is not lost. Each arbitration loss also produces a one-cycle pulse that tells the master sequencer to let go of SDA and SCL. The SCL input is passed through a synchronizer of `SYNC_STAGES` flops. A rising edge is recognised when the previous synchronized sample is 0 and the current one is 1.

Top module: `i2c_arbovr_flag`

## Requirements
- R1: While and after reset, `flag_o` and `arb_lost_pulse_o` are 0.
- R2: With the I2C format (`fmt_sync_i`=0), master (`mode_master_i`=1) and transmit (`mode_tx_i`=1) selected, a rising SCL edge seen while `sda_drive_i` differs from `sda_pin_i` sets `flag_o`. The flag becomes visible `SYNC_STAGES`+1 clock edges after `scl_i` rises. A mismatch with no SCL rise, or a rise with matching levels, leaves the flag at 0.
- R3: An SDA mismatch at an SCL rise does not set the flag in slave mode, in receive mode, or with the clocked synchronous format.
- R4: With the I2C format and master mode selected, `start_det_i` set while `sda_drive_i`=1 raises the flag one cycle later. A start seen while driving low, in slave mode, or with the clocked synchronous format is ignored.
- R5: With the clocked synchronous format selected, `final_bit_i` set while `rx_full_i`=1 raises the flag one cycle later, in either master or slave mode. Without `rx_full_i`, or with the I2C format, nothing happens.
- R6: A write with `reg_wdata_i`=0 clears the flag on the next edge only when a read was made while the flag was 1 and no other write or set event came after that read. A write of 0 with no such read leaves the flag at 1. A read made while the flag is 0 arms nothing.
- R7: Writing 1 never changes the flag, and it cancels any pending read, so a later write of 0 does not clear.
- R8: A set event between the read of 1 and the write of 0 cancels the pending read, and the flag stays 1 after that write.
- R9: When a set event and a valid clearing write fall in the same cycle, the flag is 1 afterwards.
- R10: `arb_lost_pulse_o` is high for exactly one cycle, in the same cycle the flag rises for an R2 or R4 cause. It stays low for an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_master_i | input | 1 | 1 = master, 0 = slave |
| mode_tx_i | input | 1 | 1 = transmit, 0 = receive |
| fmt_sync_i | input | 1 | 1 = clocked synchronous format, 0 = I2C format |
| sda_drive_i | input | 1 | SDA level the port itself drives |
| sda_pin_i | input | 1 | Sampled SDA pin level |
| scl_i | input | 1 | SCL pin level (synchronized inside) |
| start_det_i | input | 1 | Start condition detected, one-cycle strobe |
| final_bit_i | input | 1 | Last bit of a frame received, one-cycle strobe |
| rx_full_i | input | 1 | Receive data register still holds an unread byte |
| reg_rd_i | input | 1 | Status register read strobe |
| reg_wr_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | 1 | Value written to the flag bit |
| flag_o | output | 1 | Arbitration-lost / overrun flag |
| arb_lost_pulse_o | output | 1 | One-cycle bus release request on arbitration loss |

## Verification
The assertions take the start-detect and final-bit strobes to be single-cycle and to be separated by at least one quiet cycle. Under that assumption, two arbitration events never land back to back, and the release pulse is never longer than one cycle. They also take the mode selectors to stay steady while an event is being judged. The stimulus changes inputs only at the falling clock edge, raises each strobe for one cycle, sets the modes several cycles before SCL rises, and holds SCL steady long enough for the synchronizer to settle.

// File: rtl/arbovr_pkg.sv
package arbovr_pkg;

    // Registered state of the status bit and its clear handshake
    typedef struct packed {
        logic flag;   // shared arbitration-lost / overrun bit
        logic armed;  // read-of-1 seen, clear permitted
        logic pulse;  // bus release request
    } flag_state_t;

    localparam flag_state_t FLAG_RESET = '{flag: 1'b0, armed: 1'b0, pulse: 1'b0};

endpackage

// File: rtl/arbovr_scl_rise.sv
module arbovr_scl_rise #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    output logic scl_rise_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } scl_state_t;

    scl_state_t st_d, st_q;
    logic [SYNC_STAGES-1:0] shifted;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            assign shifted = scl_i;
        end else begin : g_chain
            assign shifted = {st_q.sync[SYNC_STAGES-2:0], scl_i};
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.sync = shifted;
        st_d.prev = st_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign scl_rise_o = st_q.sync[SYNC_STAGES-1] & ~st_q.prev;

    // A rise cannot repeat on the next cycle: the sample that made it becomes prev
    assert_rise_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_o |=> !scl_rise_o);

endmodule

// File: rtl/arbovr_events.sv
module arbovr_events (
    input  logic mode_master_i,
    input  logic mode_tx_i,
    input  logic fmt_sync_i,
    input  logic sda_drive_i,
    input  logic sda_pin_i,
    input  logic scl_rise_i,
    input  logic start_det_i,
    input  logic final_bit_i,
    input  logic rx_full_i,
    output logic arb_evt_o,
    output logic set_evt_o
);
    logic i2c_master, bit_lost, start_lost, overrun;

    always_comb begin
        i2c_master = mode_master_i & ~fmt_sync_i;
        bit_lost   = i2c_master & mode_tx_i & scl_rise_i & (sda_drive_i ^ sda_pin_i);
        start_lost = i2c_master & start_det_i & sda_drive_i;
        overrun    = fmt_sync_i & final_bit_i & rx_full_i;
        arb_evt_o  = bit_lost | start_lost;
        set_evt_o  = arb_evt_o | overrun;
    end

    // Arbitration events can only arise in the I2C format
    always_comb begin
        assert_arb_only_i2c_R3: assert (!(arb_evt_o && fmt_sync_i));
    end

endmodule

// File: rtl/arbovr_flag_reg.sv
module arbovr_flag_reg
    import arbovr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt_i,
    input  logic arb_evt_i,
    input  logic reg_rd_i,
    input  logic reg_wr_i,
    input  logic reg_wdata_i,
    output logic flag_o,
    output logic pulse_o
);
    flag_state_t st_d, st_q;
    logic clear_ok;

    always_comb begin
        st_d     = st_q;
        clear_ok = reg_wr_i & ~reg_wdata_i & st_q.armed;

        // set wins over a clearing write in the same cycle
        if (set_evt_i)     st_d.flag = 1'b1;
        else if (clear_ok) st_d.flag = 1'b0;

        // any set event or write cancels a pending read
        if (set_evt_i || reg_wr_i)       st_d.armed = 1'b0;
        else if (reg_rd_i && st_q.flag)  st_d.armed = 1'b1;

        st_d.pulse = arb_evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLAG_RESET;
        else        st_q <= st_d;
    end

    assign flag_o  = st_q.flag;
    assign pulse_o = st_q.pulse;

    assert_rise_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(set_evt_i));

    assert_clear_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag) |-> $past(st_q.armed && reg_wr_i && !reg_wdata_i));

    assert_write_one_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_wdata_i && !set_evt_i) |=> $stable(st_q.flag));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt_i |=> st_q.flag);

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);

    assert_pulse_with_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> st_q.flag);

endmodule

// File: rtl/i2c_arbovr_flag.sv
module i2c_arbovr_flag #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_master_i,
    input  logic mode_tx_i,
    input  logic fmt_sync_i,
    input  logic sda_drive_i,
    input  logic sda_pin_i,
    input  logic scl_i,
    input  logic start_det_i,
    input  logic final_bit_i,
    input  logic rx_full_i,
    input  logic reg_rd_i,
    input  logic reg_wr_i,
    input  logic reg_wdata_i,
    output logic flag_o,
    output logic arb_lost_pulse_o
);
    logic scl_rise, arb_evt, set_evt;

    arbovr_scl_rise #(.SYNC_STAGES(SYNC_STAGES)) i_scl_rise (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .scl_rise_o (scl_rise)
    );

    arbovr_events i_events (
        .mode_master_i (mode_master_i),
        .mode_tx_i     (mode_tx_i),
        .fmt_sync_i    (fmt_sync_i),
        .sda_drive_i   (sda_drive_i),
        .sda_pin_i     (sda_pin_i),
        .scl_rise_i    (scl_rise),
        .start_det_i   (start_det_i),
        .final_bit_i   (final_bit_i),
        .rx_full_i     (rx_full_i),
        .arb_evt_o     (arb_evt),
        .set_evt_o     (set_evt)
    );

    arbovr_flag_reg i_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_evt_i   (set_evt),
        .arb_evt_i   (arb_evt),
        .reg_rd_i    (reg_rd_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .flag_o      (flag_o),
        .pulse_o     (arb_lost_pulse_o)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!flag_o && !arb_lost_pulse_o));

endmodule

// File: tb/test_i2c_arbovr_flag.sv
module test_i2c_arbovr_flag;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mst, tx, fsync, drv, pin, scl, start, fin, rxf, rd, wr, wd;
    logic flag, pulse;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    i2c_arbovr_flag i_i2c_arbovr_flag (
        .clk(clk), .rst_n(rst_n), .mode_master_i(mst), .mode_tx_i(tx),
        .fmt_sync_i(fsync), .sda_drive_i(drv), .sda_pin_i(pin), .scl_i(scl),
        .start_det_i(start), .final_bit_i(fin), .rx_full_i(rxf),
        .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wd),
        .flag_o(flag), .arb_lost_pulse_o(pulse)
    );

    // {master, tx, sync_fmt, drive, pin, start, final, rx_full, exp_flag, exp_pulse}
    localparam int NV = 9;
    localparam logic [9:0] VEC [NV] = '{
        10'b1_0_0_1_1_1_0_0_1_1,  // R4 start while driving high
        10'b1_0_0_0_0_1_0_0_0_0,  // R4 start while driving low
        10'b0_0_0_1_1_1_0_0_0_0,  // R4 slave start
        10'b1_0_1_1_1_1_0_0_0_0,  // R4 start in sync format
        10'b1_0_1_0_0_0_1_1_1_0,  // R5 overrun, master, no pulse (R10)
        10'b0_0_1_0_0_0_1_1_1_0,  // R5 overrun, slave
        10'b0_0_1_0_0_0_1_0_0_0,  // R5 final bit, buffer empty
        10'b0_0_0_0_0_0_1_1_0_0,  // R5 final bit in I2C format
        10'b1_1_0_1_0_0_0_0_0_0   // R2 mismatch without SCL rise
    };

    task automatic check(input logic act, input logic exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle();
        start = 0; fin = 0; rxf = 0; rd = 0; wr = 0; wd = 0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_read();
        rd = 1; tick(); rd = 0;
    endtask

    task automatic do_write(input logic v);
        wr = 1; wd = v; tick(); wr = 0; wd = 0;
    endtask

    task automatic clear_flag();
        do_read(); do_write(1'b0); tick();
        check(flag, 1'b0, "R6 handshake clear");
    endtask

    // raise SCL, return after flag should be visible (SYNC_STAGES+1 edges)
    task automatic scl_rise_and_wait(output logic pulse_seen);
        scl = 1; tick(); tick(); tick();
        pulse_seen = pulse;
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic p;
        mst = 0; tx = 0; fsync = 0; drv = 1; pin = 1; scl = 0; idle();
        tick(); tick();
        check(flag, 1'b0, "R1 flag in reset");
        check(pulse, 1'b0, "R1 pulse in reset");
        rst_n = 1; tick();
        check(flag, 1'b0, "R1 flag after reset");

        // vector table
        for (int v = 0; v < NV; v++) begin
            {mst, tx, fsync, drv, pin} = VEC[v][9:5];
            tick();
            start = VEC[v][4]; fin = VEC[v][3]; rxf = VEC[v][2];
            tick();
            idle();
            check(flag, VEC[v][1], $sformatf("R4/R5 vector %0d flag", v));
            check(pulse, VEC[v][0], $sformatf("R10 vector %0d pulse", v));
            tick();
            check(pulse, 1'b0, $sformatf("R10 vector %0d pulse width", v));
            if (flag) clear_flag();
        end

        // R2: mismatch at SCL rise, timing of the synchronizer
        mst = 1; tx = 1; fsync = 0; drv = 1; pin = 0; scl = 0; tick(); tick(); tick();
        scl = 1; tick();
        check(flag, 1'b0, "R2 one edge after SCL rise");
        tick();
        check(flag, 1'b0, "R2 two edges after SCL rise");
        tick();
        check(flag, 1'b1, "R2 flag after SCL rise mismatch");
        check(pulse, 1'b1, "R10 pulse on bit loss");
        tick();
        check(pulse, 1'b0, "R10 pulse ends");
        check(flag, 1'b1, "R2 flag holds");
        scl = 0; tick(); tick(); tick();
        clear_flag();

        // R2: matching levels at rise
        drv = 0; pin = 0; scl_rise_and_wait(p);
        tick(); check(flag, 1'b0, "R2 match at rise");
        scl = 0; tick(); tick(); tick();

        // R3: receive mode, slave mode, sync format
        tx = 0; drv = 1; pin = 0; scl_rise_and_wait(p);
        tick(); check(flag, 1'b0, "R3 receive mode");
        scl = 0; tick(); tick(); tick();
        tx = 1; mst = 0; scl_rise_and_wait(p);
        tick(); check(flag, 1'b0, "R3 slave mode");
        scl = 0; tick(); tick(); tick();
        mst = 1; fsync = 1; scl_rise_and_wait(p);
        tick(); check(flag, 1'b0, "R3 sync format");
        scl = 0; tick(); tick(); tick();

        // set flag via overrun for handshake tests
        fsync = 1; mst = 0; drv = 1; pin = 1;
        fin = 1; rxf = 1; tick(); idle(); tick();
        check(flag, 1'b1, "R5 set for handshake");

        // R6: write 0 without read
        do_write(1'b0); tick();
        check(flag, 1'b1, "R6 write 0 without read");
        // R7: read, write 1, write 0
        do_read(); do_write(1'b1); tick();
        check(flag, 1'b1, "R7 write 1 inert");
        do_write(1'b0); tick();
        check(flag, 1'b1, "R7 write 1 cancels read");
        // R8: read, set event, write 0
        do_read();
        fin = 1; rxf = 1; tick(); idle();
        do_write(1'b0); tick();
        check(flag, 1'b1, "R8 event between read and write");
        // R9: read, then write 0 together with set event
        do_read();
        fin = 1; rxf = 1; wr = 1; wd = 0; tick(); idle(); tick();
        check(flag, 1'b1, "R9 set wins over clear");
        clear_flag();
        // R6: read while 0 does not arm
        do_read();
        fin = 1; rxf = 1; tick(); idle(); tick();
        do_write(1'b0); tick();
        check(flag, 1'b1, "R6 read of 0 arms nothing");
        clear_flag();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule